// File: doc/BRIEF.md
# Raster Scanline Timer with Vertical-Blank Interrupt

The block keeps raster timing for a tile-based video processor. Its dot clock runs at three dots per CPU cycle. Each cycle the CPU may report a number of completed CPU cycles. The timer adds three dots for each one to its dot position. When the position passes the end of a scanline, the timer wraps it, keeps the surplus dots, and moves to the next scanline. A frame has 262 scanlines.

Entering scanline 241 begins vertical blanking. At that point the block sets its blank flag and clears the sprite-zero-hit flag. It also raises an interrupt request to the CPU if interrupt generation is enabled in the control register. When the frame wraps back to scanline 0, the block clears the blank flag, the sprite-zero-hit flag and any pending request, and pulses frame-done for one cycle. Software can also raise the request during blanking by turning the enable bit on. The request is a level. It stays high until frame end or until the CPU acknowledges it.

Top module: `raster_timer`

## Requirements
- R1: After reset, dot and line are 0, and blank, sprite-zero-hit, the interrupt request, frame-done and the stored enable are all 0.
- R2: When `cyc_valid_i` is high, the dot position advances by 3 × `cyc_cnt_i`. When it is low, dot and line stay unchanged.
- R3: When the advanced dot position reaches 341 or more, it becomes the position minus 341, and the line advances by one.
- R4: Lines run from 0 to 261. A wrap out of line 261 returns the line to 0.
- R5: A wrap into line 241 sets `vblank_o` and clears `sprite0_hit_o` in the following cycle.
- R6: A wrap into line 241 raises `nmi_o` if bit 7 of the control register is 1. The value used is the one in force after any control write made in the same cycle.
- R7: A control write that changes bit 7 from 0 to 1 while `vblank_o` is 1 raises `nmi_o` in the next cycle. Other writes do not raise it.
- R8: A wrap out of line 261 clears `vblank_o`, `sprite0_hit_o` and `nmi_o` in the next cycle, and pulses `frame_done_o` for exactly that cycle. This clear wins over any set made in the same cycle.
- R9: `nmi_ack_i` clears `nmi_o` in the next cycle. A set of the request in the same cycle wins over the acknowledge.
- R10: `sprite0_set_i` sets `sprite0_hit_o`. A clear from R5 or R8 in the same cycle wins over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_valid_i | input | 1 | The cycle count is valid this cycle |
| cyc_cnt_i | input | 4 | Number of CPU cycles completed |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control write data; bit 7 enables the interrupt |
| nmi_ack_i | input | 1 | Interrupt acknowledge from the CPU |
| sprite0_set_i | input | 1 | Sprite-zero hit reported by the renderer |
| dot_o | output | 9 | Current dot within the line |
| line_o | output | 9 | Current scanline |
| vblank_o | output | 1 | Vertical-blank status flag |
| sprite0_hit_o | output | 1 | Sprite-zero-hit status flag |
| nmi_o | output | 1 | Non-maskable interrupt request level |
| frame_done_o | output | 1 | One-cycle pulse at frame wrap |

## Verification
Several pairs of events can fall in the same cycle:
- the blank-entry wrap and a control write that turns the enable on;
- the frame-end wrap and an enable write that rises during blanking;
- an acknowledge and a new request;
- a sprite-zero set and a flag clear.

The bench makes each of these coincide on purpose. It fast-forwards with large cycle counts, then single-steps until the next step is known to wrap, and applies the second event on that step. A reference model written from R5 to R10 predicts every flag. The bench compares each flag in the cycle after the edge. A long pseudo-random run then mixes all the inputs over several frames.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int CTRL_W          = 8;
  localparam int CTRL_NMI_EN_BIT = 7;
endpackage

// File: rtl/raster_dot_ctr.sv
module raster_dot_ctr #(
  parameter int DOTS  = 341,
  parameter int DPC   = 3,
  parameter int CYC_W = 4,
  localparam int DOT_W = $clog2(DOTS),
  localparam int SUM_W = DOT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [CYC_W-1:0] cyc_i,
  output logic [DOT_W-1:0] dot_o,
  output logic             wrap_o
);
  logic [DOT_W-1:0] dot_q, dot_d;
  logic [SUM_W-1:0] sum;

  // one wrap per step: max advance must stay below DOTS
  always_comb begin
    sum    = {1'b0, dot_q} + SUM_W'(cyc_i) * SUM_W'(DPC);
    wrap_o = adv_i && (sum >= SUM_W'(DOTS));
    dot_d  = wrap_o ? DOT_W'(sum - SUM_W'(DOTS)) : DOT_W'(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dot_q <= '0;
    else if (adv_i) dot_q <= dot_d;
  end

  assign dot_o = dot_q;
endmodule

// File: rtl/raster_line_ctr.sv
module raster_line_ctr #(
  parameter int LINES = 262,
  parameter int VBL   = 241,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wrap_i,
  output logic [LINE_W-1:0] line_o,
  output logic              vbl_start_o,
  output logic              frame_end_o
);
  logic [LINE_W-1:0] line_q;

  assign frame_end_o = wrap_i && (line_q == LINE_W'(LINES - 1));
  assign vbl_start_o = wrap_i && (line_q == LINE_W'(VBL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          line_q <= '0;
    else if (frame_end_o) line_q <= '0;
    else if (wrap_i)      line_q <= line_q + 1'b1;
  end

  assign line_o = line_q;
endmodule

// File: rtl/raster_flags.sv
module raster_flags
  import raster_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vbl_start_i,
  input  logic              frame_end_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              nmi_ack_i,
  input  logic              sprite0_set_i,
  output logic              vblank_o,
  output logic              sprite0_hit_o,
  output logic              nmi_o,
  output logic              frame_done_o
);
  logic en_q, en_d, vbl_q, s0_q, nmi_q, fd_q;
  logic en_rise, nmi_set;

  always_comb begin
    en_d    = ctrl_we_i ? ctrl_wdata_i[CTRL_NMI_EN_BIT] : en_q;
    en_rise = ctrl_we_i && !en_q && ctrl_wdata_i[CTRL_NMI_EN_BIT] && vbl_q;
    nmi_set = (vbl_start_i && en_d) || en_rise;
  end

  // priority: frame end clear > set > acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      vbl_q <= 1'b0;
      s0_q  <= 1'b0;
      nmi_q <= 1'b0;
      fd_q  <= 1'b0;
    end else begin
      en_q <= en_d;
      fd_q <= frame_end_i;
      if (frame_end_i)      vbl_q <= 1'b0;
      else if (vbl_start_i) vbl_q <= 1'b1;
      if (frame_end_i || vbl_start_i) s0_q <= 1'b0;
      else if (sprite0_set_i)         s0_q <= 1'b1;
      if (frame_end_i)    nmi_q <= 1'b0;
      else if (nmi_set)   nmi_q <= 1'b1;
      else if (nmi_ack_i) nmi_q <= 1'b0;
    end
  end

  assign vblank_o      = vbl_q;
  assign sprite0_hit_o = s0_q;
  assign nmi_o         = nmi_q;
  assign frame_done_o  = fd_q;
endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import raster_pkg::*;
#(
  parameter int DOTS  = 341,
  parameter int LINES = 262,
  parameter int VBL   = 241,
  parameter int DPC   = 3,
  parameter int CYC_W = 4,
  localparam int DOT_W  = $clog2(DOTS),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_valid_i,
  input  logic [CYC_W-1:0]  cyc_cnt_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              nmi_ack_i,
  input  logic              sprite0_set_i,
  output logic [DOT_W-1:0]  dot_o,
  output logic [LINE_W-1:0] line_o,
  output logic              vblank_o,
  output logic              sprite0_hit_o,
  output logic              nmi_o,
  output logic              frame_done_o
);
  logic wrap, vbl_start, frame_end;

  raster_dot_ctr #(.DOTS(DOTS), .DPC(DPC), .CYC_W(CYC_W)) i_dot (
    .clk_i, .rst_ni, .adv_i(cyc_valid_i), .cyc_i(cyc_cnt_i),
    .dot_o, .wrap_o(wrap)
  );

  raster_line_ctr #(.LINES(LINES), .VBL(VBL)) i_line (
    .clk_i, .rst_ni, .wrap_i(wrap), .line_o,
    .vbl_start_o(vbl_start), .frame_end_o(frame_end)
  );

  raster_flags i_flags (
    .clk_i, .rst_ni, .vbl_start_i(vbl_start), .frame_end_i(frame_end),
    .ctrl_we_i, .ctrl_wdata_i, .nmi_ack_i, .sprite0_set_i,
    .vblank_o, .sprite0_hit_o, .nmi_o, .frame_done_o
  );
endmodule

// File: rtl/raster_timer_chk.sv
module raster_timer_chk #(
  parameter int DOTS  = 341,
  parameter int LINES = 262,
  parameter int VBL   = 241,
  localparam int DOT_W  = $clog2(DOTS),
  localparam int LINE_W = $clog2(LINES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cyc_valid_i,
  input logic [DOT_W-1:0]  dot_o,
  input logic [LINE_W-1:0] line_o,
  input logic              vblank_o,
  input logic              sprite0_hit_o,
  input logic              nmi_o,
  input logic              frame_done_o
);
  AST_DOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dot_o < DOT_W'(DOTS)); // R3
  AST_LINE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o < LINE_W'(LINES)); // R4
  AST_NO_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_valid_i |=> $stable(dot_o) && $stable(line_o)); // R2
  AST_VBL_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vblank_o) |-> line_o == LINE_W'(VBL) && !sprite0_hit_o); // R5
  AST_NMI_IN_VBL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_o) |-> vblank_o); // R6
  AST_FRAME_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> line_o == '0 && !vblank_o && !nmi_o && !sprite0_hit_o); // R8
  AST_FRAME_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o); // R8
endmodule

bind raster_timer raster_timer_chk #(.DOTS(DOTS), .LINES(LINES), .VBL(VBL)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cyc_valid_i(cyc_valid_i),
  .dot_o(dot_o), .line_o(line_o), .vblank_o(vblank_o),
  .sprite0_hit_o(sprite0_hit_o), .nmi_o(nmi_o), .frame_done_o(frame_done_o)
);

// File: tb/test_raster_timer.sv
module test_raster_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, we = 1'b0, ack = 1'b0, s0set = 1'b0;
  logic [3:0] cyc = '0;
  logic [7:0] wd = '0;
  logic [8:0] dot, line;
  logic vbl, s0, nmi, fd;
  int checks = 0, fails = 0, cycles = 0;
  int m_dot = 0, m_line = 0;
  bit m_vbl = 0, m_s0 = 0, m_nmi = 0, m_fd = 0, m_en = 0;

  always #10 clk = ~clk;

  raster_timer i_raster_timer (
    .clk_i(clk), .rst_ni(rst_n), .cyc_valid_i(valid), .cyc_cnt_i(cyc),
    .ctrl_we_i(we), .ctrl_wdata_i(wd), .nmi_ack_i(ack), .sprite0_set_i(s0set),
    .dot_o(dot), .line_o(line), .vblank_o(vbl), .sprite0_hit_o(s0),
    .nmi_o(nmi), .frame_done_o(fd)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
      summary();
    end
  end

  // called at a negedge: drive, let one edge pass, update model, compare
  task automatic step(int c, bit v, bit w, logic [7:0] d, bit a, bit s);
    int sum;
    bit wrap, vs, fe, en_new, rise;
    cyc = 4'(c); valid = v; we = w; wd = d; ack = a; s0set = s;
    @(posedge clk);
    sum    = m_dot + (v ? c * 3 : 0);
    wrap   = sum >= 341;
    vs     = wrap && m_line == 240;
    fe     = wrap && m_line == 261;
    en_new = w ? d[7] : m_en;
    rise   = w && !m_en && d[7] && m_vbl;
    m_dot  = wrap ? sum - 341 : sum;
    m_line = fe ? 0 : (wrap ? m_line + 1 : m_line);
    m_vbl  = fe ? 0 : (vs ? 1 : m_vbl);
    m_s0   = (fe || vs) ? 0 : (s ? 1 : m_s0);
    m_nmi  = fe ? 0 : (((vs && en_new) || rise) ? 1 : (a ? 0 : m_nmi));
    m_fd   = fe;
    m_en   = en_new;
    @(negedge clk);
    valid = 0; we = 0; ack = 0; s0set = 0;
    chk("R3 dot", int'(dot), m_dot);
    chk("R4 line", int'(line), m_line);
    chk("R5 vblank", int'(vbl), int'(m_vbl));
    chk("R10 sprite0", int'(s0), int'(m_s0));
    chk("R6 nmi", int'(nmi), int'(m_nmi));
    chk("R8 frame_done", int'(fd), int'(m_fd));
  endtask

  // stop when the next single-cycle step wraps out of line l
  task automatic run_to_wrap(int l);
    while (m_line != l || m_dot + 45 < 338) step(15, 1, 0, 8'h00, 0, 0);
    while (m_dot + 3 < 341) step(1, 1, 0, 8'h00, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dot", int'(dot), 0);
    chk("R1 line", int'(line), 0);
    chk("R1 flags", int'({vbl, s0, nmi, fd}), 0);

    for (int k = 0; k < 3; k++) step(15, 0, 0, 8'h00, 0, 0);
    chk("R2 hold dot", int'(dot), 0);
    for (int k = 1; k < 16; k++) step(k, 1, 0, 8'h00, 0, 0);
    chk("R2 sum", int'(dot), 3 * 120 - 341);

    // enable write coincides with blank entry
    run_to_wrap(240);
    step(1, 1, 1, 8'h80, 0, 0);
    chk("R6 coincident enable", int'(nmi), 1);
    step(0, 0, 0, 8'h00, 1, 0);
    chk("R9 ack", int'(nmi), 0);
    step(0, 0, 1, 8'h00, 0, 0);
    step(0, 0, 1, 8'h80, 0, 0);
    chk("R7 rise in vblank", int'(nmi), 1);
    step(0, 0, 0, 8'h00, 1, 0);
    step(0, 0, 1, 8'h80, 0, 0);
    chk("R7 no rise", int'(nmi), 0);
    step(0, 0, 1, 8'h00, 0, 0);
    step(0, 0, 1, 8'h80, 1, 0);
    chk("R9 set beats ack", int'(nmi), 1);
    step(0, 0, 1, 8'h00, 1, 1);
    chk("R10 set", int'(s0), 1);

    // rising enable coincides with frame end
    run_to_wrap(261);
    step(1, 1, 1, 8'h80, 0, 1);
    chk("R8 clear wins nmi", int'(nmi), 0);
    chk("R8 clear wins sprite0", int'(s0), 0);
    chk("R8 pulse", int'(fd), 1);
    step(0, 0, 0, 8'h00, 0, 0);
    chk("R8 pulse end", int'(fd), 0);
    step(0, 0, 0, 8'h00, 0, 1);

    // plain blank entry with enable on; sprite0 set coincident
    run_to_wrap(240);
    step(1, 1, 0, 8'h00, 0, 1);
    chk("R6 entry", int'(nmi), 1);
    chk("R5 sprite0 cleared", int'(s0), 0);
    step(0, 0, 1, 8'h00, 1, 0);
    run_to_wrap(261);
    step(1, 1, 0, 8'h00, 0, 0);
    run_to_wrap(240);
    step(1, 1, 0, 8'h00, 0, 0);
    chk("R6 disabled", int'(nmi), 0);
    chk("R5 vblank", int'(vbl), 1);

    // mixed sweep over several frames
    for (int k = 0; k < 12000; k++)
      step((k * 7) % 16, (k % 9) != 0, (k % 61) == 0, ((k / 61) % 2) ? 8'h80 : 8'h7f,
           (k % 37) == 0, (k % 43) == 0);
    summary();
  end
endmodule